// File: doc/BRIEF.md
# Dual-Channel Fault Event Counters

This block accumulates fault events for a controller that drives two regulator outputs. Once per switching cycle a strobe marks the moment to sample four already-debounced comparator flags: an undervoltage flag and an overcurrent flag for each channel. Two saturating counters tally the events, one for each fault kind. When a channel faults on its own, its counter rises by one. When both channels fault in the same cycle, it rises by two.

The two counters clear under different rules. The undervoltage tally only ever grows until the sequencer clears it. The overcurrent tally falls back to zero on any sampled cycle in which neither channel is over its limit. When either tally reaches its top value, the block raises a registered shutdown request for both outputs. That request stays high, and both tallies hold their values, until the sequencer pulses the synchronous clear.

Top module: `fault_tally`

## Requirements
- R1: After reset, and one clock after `clr` is sampled high, both counts read 0 and `shutdown` is low.
- R2: On a strobe with exactly one bit of `uv_flag` set, `uv_count` rises by 1 at the next clock.
- R3: On a strobe with both bits of `uv_flag` set, `uv_count` rises by 2 at the next clock.
- R4: On a strobe with no `uv_flag` bit set, `uv_count` keeps its value. Undervoltage flags never lower the count.
- R5: On a strobe, `oc_count` rises by the number of set `oc_flag` bits, which is 1 or 2.
- R6: On a strobe with both `oc_flag` bits clear, `oc_count` returns to 0 at the next clock.
- R7: The counts saturate at 15. An increase of 2 from 14, or any increase from 15, leaves the count at 15, and a count never wraps to a smaller value.
- R8: `shutdown` goes high on the same clock edge at which either count becomes 15.
- R9: While `shutdown` is high, both counts and `shutdown` hold their values until `clr` is sampled high.
- R10: With `strobe` low, changes on the flags have no effect on any output.
- R11: When `clr` and `strobe` are high in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear from the sequencer |
| strobe | input | 1 | One-clock marker for the switching-cycle sample point |
| uv_flag | input | 2 | Undervoltage flags; bit 0 is channel A, bit 1 is channel B |
| oc_flag | input | 2 | Overcurrent flags; bit 0 is channel A, bit 1 is channel B |
| shutdown | output | 1 | Registered request to shut down both regulators |
| uv_count | output | CW | Undervoltage event count |
| oc_count | output | CW | Overcurrent event count |

## Verification
The hardest cases to reach are the edges of saturation. The bench has to land the undervoltage count on exactly 14 and then apply a double event, which should stop at 15 and not wrap. It must also walk the overcurrent count up to 15 using only single events, with no clean cycle along the way that would reset it. Directed runs build both approaches one step at a time. They then keep strobing with faults present to confirm the frozen state, and apply a clear in the same cycle as a strobe. A randomized phase follows that mixes strobe gaps, flag toggles and clears, compared on every clock against the behavioural model.

// File: rtl/fault_tally.sv
module fault_tally #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          strobe,
  input  logic [1:0]    uv_flag,
  input  logic [1:0]    oc_flag,
  output logic          shutdown,
  output logic [CW-1:0] uv_count,
  output logic [CW-1:0] oc_count
);

  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [CW:0]   uv_sum, oc_sum;
  logic [CW-1:0] uv_nx, oc_nx;
  logic          live;

  assign live   = strobe && !shutdown;
  assign uv_sum = {1'b0, uv_count} + (CW+1)'(uv_flag[0]) + (CW+1)'(uv_flag[1]);
  assign oc_sum = {1'b0, oc_count} + (CW+1)'(oc_flag[0]) + (CW+1)'(oc_flag[1]);
  assign uv_nx  = uv_sum[CW] ? TOP : uv_sum[CW-1:0];
  assign oc_nx  = (oc_flag == 2'b00) ? '0 : (oc_sum[CW] ? TOP : oc_sum[CW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_count <= '0;
      oc_count <= '0;
      shutdown <= 1'b0;
    end else if (clr) begin
      uv_count <= '0;
      oc_count <= '0;
      shutdown <= 1'b0;
    end else if (live) begin
      uv_count <= uv_nx;
      oc_count <= oc_nx;
      shutdown <= (uv_nx == TOP) || (oc_nx == TOP);
    end
  end

  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (uv_count == '0) && (oc_count == '0) && !shutdown);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !clr) |=> $stable(uv_count) && $stable(oc_count) && $stable(shutdown));

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> uv_count >= $past(uv_count));

  a_r6_oc_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !clr && !shutdown && oc_flag == 2'b00) |=> oc_count == '0);

  a_r8_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_count == TOP || oc_count == TOP) |-> shutdown);

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !clr) |=> shutdown && $stable(uv_count) && $stable(oc_count));

endmodule

// File: tb/fault_tally_tb.sv
module fault_tally_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic strobe = 1'b0;
  logic [1:0] uv_flag = 2'b00;
  logic [1:0] oc_flag = 2'b00;
  logic shutdown;
  logic [3:0] uv_count, oc_count;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string tag = "R1";
  int m_uv = 0, m_oc = 0;
  bit m_sd = 0;

  always #5 clk = ~clk;

  fault_tally #(.CW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .strobe(strobe),
    .uv_flag(uv_flag), .oc_flag(oc_flag),
    .shutdown(shutdown), .uv_count(uv_count), .oc_count(oc_count)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_uv = 0; m_oc = 0; m_sd = 0;
    end else if (clr) begin
      m_uv = 0; m_oc = 0; m_sd = 0;
    end else if (strobe && !m_sd) begin
      m_uv = m_uv + uv_flag[0] + uv_flag[1];
      if (m_uv > 15) m_uv = 15;
      if (oc_flag == 2'b00) m_oc = 0;
      else begin
        m_oc = m_oc + oc_flag[0] + oc_flag[1];
        if (m_oc > 15) m_oc = 15;
      end
      if (m_uv == 15 || m_oc == 15) m_sd = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (int'(uv_count) != m_uv || int'(oc_count) != m_oc || shutdown != m_sd) begin
        n_bad++;
        $display("FAIL %s: actual uv=%0d oc=%0d sd=%0b expected uv=%0d oc=%0d sd=%0b",
                 tag, uv_count, oc_count, shutdown, m_uv, m_oc, m_sd);
      end
    end
  end

  task automatic step(input bit s, input logic [1:0] u, input logic [1:0] o, input bit c);
    @(negedge clk); #1;
    strobe = s; uv_flag = u; oc_flag = o; clr = c;
  endtask

  task automatic expect_now(input string r, input int eu, input int eo, input bit es);
    @(negedge clk); #2;
    n_cmp++;
    if (int'(uv_count) != eu || int'(oc_count) != eo || shutdown != es) begin
      n_bad++;
      $display("FAIL %s: actual uv=%0d oc=%0d sd=%0b expected uv=%0d oc=%0d sd=%0b",
               r, uv_count, oc_count, shutdown, eu, eo, es);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_now("R1", 0, 0, 0);

    tag = "R10";
    for (int i = 0; i < 6; i++) step(0, 2'(i), 2'(i + 1), 0);
    step(0, 2'b00, 2'b00, 0);
    expect_now("R10", 0, 0, 0);

    tag = "R2";
    step(1, 2'b01, 2'b00, 0);
    step(1, 2'b10, 2'b00, 0);
    step(0, 2'b00, 2'b00, 0);
    expect_now("R2", 2, 0, 0);

    tag = "R3";
    step(1, 2'b11, 2'b00, 0);
    step(0, 2'b00, 2'b00, 0);
    expect_now("R3", 4, 0, 0);

    tag = "R4";
    step(1, 2'b01, 2'b00, 0);
    step(1, 2'b00, 2'b00, 0);
    step(0, 2'b00, 2'b00, 0);
    expect_now("R4", 5, 0, 0);

    tag = "R5";
    step(1, 2'b00, 2'b01, 0);
    step(1, 2'b00, 2'b11, 0);
    step(0, 2'b00, 2'b00, 0);
    expect_now("R5", 5, 3, 0);

    tag = "R6";
    step(1, 2'b00, 2'b00, 0);
    step(0, 2'b00, 2'b00, 0);
    expect_now("R6", 5, 0, 0);

    tag = "R7";
    for (int i = 0; i < 9; i++) step(1, 2'b10, 2'b00, 0);
    step(0, 2'b00, 2'b00, 0);
    expect_now("R7", 14, 0, 0);
    step(1, 2'b11, 2'b00, 0);
    step(0, 2'b00, 2'b00, 0);
    expect_now("R8", 15, 0, 1);

    tag = "R9";
    for (int i = 0; i < 4; i++) step(1, 2'b11, 2'b11, 0);
    step(0, 2'b00, 2'b00, 0);
    expect_now("R9", 15, 0, 1);

    tag = "R11";
    step(1, 2'b11, 2'b11, 1);
    step(0, 2'b00, 2'b00, 0);
    expect_now("R11", 0, 0, 0);

    tag = "R8";
    for (int i = 0; i < 15; i++) step(1, 2'b00, 2'(1 + (i % 2)), 0);
    step(0, 2'b00, 2'b00, 0);
    expect_now("R8", 0, 15, 1);
    step(0, 2'b00, 2'b00, 1);
    step(0, 2'b00, 2'b00, 0);
    expect_now("R1", 0, 0, 0);

    tag = "R7";
    for (int i = 0; i < 7; i++) step(1, 2'b00, 2'b11, 0);
    step(0, 2'b00, 2'b00, 0);
    expect_now("R7", 0, 14, 0);
    step(1, 2'b00, 2'b11, 0);
    step(0, 2'b00, 2'b00, 0);
    expect_now("R7", 0, 15, 1);
    step(0, 2'b00, 2'b00, 1);

    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      automatic int r = $urandom_range(0, 99);
      step(r < 60, 2'($urandom), ($urandom_range(0, 3) == 0) ? 2'b00 : 2'($urandom), r > 96);
    end
    step(0, 2'b00, 2'b00, 0);
    @(negedge clk);
    finish_run();
  end
endmodule